// File: doc/BRIEF.md
# Packet Ready Tracker

The block keeps, for each of 32 queues, a count of how many whole packets are stored in the queue. The write side tags words with start and end markers. The read side reports when it consumes a word that closes a packet. From these counts the block drives two outputs: an active-low ready vector with one bit per queue, and a registered active-low ready flag for the queue that the read side currently selects. The data words themselves are held elsewhere. The block only sees their markers and queue numbers.

The operating mode is set during reset. While reset is low, a strap input and two port-width inputs are sampled every clock. The block runs in packet mode only if the strap is high and both ports are configured 36 bits wide. Otherwise it runs in plain almost-empty mode. In that mode the tracker stays idle and every ready output stays high. After reset the mode is fixed until the next reset.

The write-side framer is a two-state machine:
- FR_IDLE means no packet is open. From FR_IDLE, a start-only word takes the transition "open" to FR_OPEN. A word carrying both markers takes the transition "single", which completes a packet and stays in FR_IDLE. An end-only word takes the transition "orphan", which raises an error and stays in FR_IDLE.
- From FR_OPEN, an end word on the same queue takes the transition "close", which completes the packet and returns to FR_IDLE. A word on any other queue takes the transition "abandon", which raises an error and returns to FR_IDLE.

The mode register has two states, MD_PLAIN and MD_PACKET. It takes the transition "latch" on every clock while reset is low.

Top module: `pkt_ready_tracker`

## Requirements
- R1: Packet mode is active only if `mode_strap`, `in_w36` and `out_w36` are all 1 at the last clock edge of reset. Otherwise `pr_n` and every bit of `ready_n_vec` stay 1 and no error output rises, whatever the traffic and whatever the strap does after reset.
- R2: A packet is a start word, then optional middle words, then an end word, all on one queue. Once the end word has been written, `ready_n_vec[q]` is 0 after that edge. `pr_n` shows `ready_n_vec[rd_q]` one edge later.
- R3: A single word written with both `wr_sop` and `wr_eop` set counts as one complete packet.
- R4: A read with `rd_eop`=1 on a queue holding packets lowers its count by one, and `ready_n_vec[q]` returns to 1 when the count reaches zero. A read with `rd_eop`=0 changes nothing.
- R5: If a packet completes on a queue that holds at least one packet, and an end word is read from that same queue in the same cycle, the count does not change.
- R6: An end-only word written while no packet is open does not change any count. `err_orphan` is 1 for the single cycle after that edge.
- R7: A write to a different queue while a packet is open abandons that packet, and the switching word is ignored. `err_switch` is 1 for one cycle and no count changes. At most one of `err_switch`, `err_orphan` and `ovf` is 1 at a time.
- R8: A count holds at its maximum of 2^CNT_W-1 (15 by default) instead of wrapping. A packet that completes on a full queue raises `ovf` for one cycle.
- R9: An end word read from a queue whose count is zero leaves the count at zero.
- R10: While reset is low, and in the first cycle after it, `pr_n`=1, `ready_n_vec` is all ones, and the error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; mode inputs sampled while low |
| mode_strap | input | 1 | 1 requests packet mode |
| in_w36 | input | 1 | 1 when the write port is 36 bits wide |
| out_w36 | input | 1 | 1 when the read port is 36 bits wide |
| wr_en | input | 1 | Write word strobe |
| wr_q | input | 5 | Write queue index |
| wr_sop | input | 1 | Start-of-packet marker on the written word |
| wr_eop | input | 1 | End-of-packet marker on the written word |
| rd_en | input | 1 | Read word strobe |
| rd_q | input | 5 | Read queue index, also selects `pr_n` |
| rd_eop | input | 1 | End-of-packet marker on the read word |
| pr_n | output | 1 | Registered ready flag of the selected read queue, active low |
| ready_n_vec | output | 32 | Per-queue ready flags, active low |
| err_switch | output | 1 | Queue changed in mid-packet |
| err_orphan | output | 1 | End marker with no open packet |
| ovf | output | 1 | Packet completed on a saturated counter |

## Verification
The counters and the three error outputs all update at the edge that samples the word. They can therefore be read at the falling edge that follows that edge. `pr_n` has one more register stage, so it is due one full cycle after the ready vector.

The bench applies stimulus at a falling edge and reads results at the next falling edge. Where `pr_n` matters, it holds `rd_q` steady for one extra idle cycle before checking. It proves that a count is at zero, or at a given value, by reading packets back out and watching the exact cycle in which the ready bit rises.

// File: rtl/pkt_ready_pkg.sv
package pkt_ready_pkg;
    typedef enum logic {MD_PLAIN, MD_PACKET} mode_e;
    typedef enum logic {FR_IDLE, FR_OPEN} frame_e;
endpackage

// File: rtl/pkt_wr_framer.sv
module pkt_wr_framer
    import pkt_ready_pkg::*;
#(
    parameter int QW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wr_en,
    input  logic [QW-1:0] wr_q,
    input  logic          wr_sop,
    input  logic          wr_eop,
    output logic          done,
    output logic [QW-1:0] done_q,
    output logic          orphan,
    output logic          switch_err
);
    frame_e        state, state_nxt;
    logic [QW-1:0] open_q, open_q_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FR_IDLE;
            open_q <= '0;
        end else begin
            state  <= state_nxt;
            open_q <= open_q_nxt;
        end
    end

    // transitions and outputs
    always_comb begin
        state_nxt  = state;
        open_q_nxt = open_q;
        done       = 1'b0;
        orphan     = 1'b0;
        switch_err = 1'b0;
        done_q     = wr_q;
        unique case (state)
            FR_IDLE: begin
                if (enable && wr_en) begin
                    if (wr_sop && wr_eop) begin
                        done = 1'b1;                 // single
                    end else if (wr_sop) begin
                        state_nxt  = FR_OPEN;        // open
                        open_q_nxt = wr_q;
                    end else if (wr_eop) begin
                        orphan = 1'b1;               // orphan
                    end
                end
            end
            FR_OPEN: begin
                if (enable && wr_en) begin
                    if (wr_q != open_q) begin
                        switch_err = 1'b1;           // abandon
                        state_nxt  = FR_IDLE;
                    end else if (wr_eop) begin
                        done      = 1'b1;            // close
                        state_nxt = FR_IDLE;
                    end
                end
            end
            default: state_nxt = FR_IDLE;
        endcase
    end
endmodule

// File: rtl/pkt_cnt_cell.sv
module pkt_cnt_cell #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero,
    output logic sat_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             dec_ok;
    logic             full;

    assign full    = (cnt == CNT_MAX);
    assign nonzero = (cnt != '0);
    assign dec_ok  = dec && nonzero;
    assign sat_hit = inc && !dec_ok && full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec_ok})
                2'b10:   if (!full) cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker
    import pkt_ready_pkg::*;
#(
    parameter int NUM_Q = 32,
    parameter int CNT_W = 4,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_strap,
    input  logic             in_w36,
    input  logic             out_w36,
    input  logic             wr_en,
    input  logic [QW-1:0]    wr_q,
    input  logic             wr_sop,
    input  logic             wr_eop,
    input  logic             rd_en,
    input  logic [QW-1:0]    rd_q,
    input  logic             rd_eop,
    output logic             pr_n,
    output logic [NUM_Q-1:0] ready_n_vec,
    output logic             err_switch,
    output logic             err_orphan,
    output logic             ovf
);
    mode_e            mode;
    logic             pkt_mode;
    logic             fr_done, fr_orphan, fr_switch;
    logic [QW-1:0]    fr_q;
    logic [NUM_Q-1:0] q_nz, q_sat;

    // mode register: latch on every clock while reset is low
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= (mode_strap && in_w36 && out_w36) ? MD_PACKET : MD_PLAIN;
    end

    assign pkt_mode = (mode == MD_PACKET);

    pkt_wr_framer #(.QW(QW)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (pkt_mode),
        .wr_en      (wr_en),
        .wr_q       (wr_q),
        .wr_sop     (wr_sop),
        .wr_eop     (wr_eop),
        .done       (fr_done),
        .done_q     (fr_q),
        .orphan     (fr_orphan),
        .switch_err (fr_switch)
    );

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        pkt_cnt_cell #(.CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (fr_done && (fr_q == QW'(i))),
            .dec     (pkt_mode && rd_en && rd_eop && (rd_q == QW'(i))),
            .nonzero (q_nz[i]),
            .sat_hit (q_sat[i])
        );
        assign ready_n_vec[i] = !(pkt_mode && q_nz[i]);
    end

    // output register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pr_n       <= 1'b1;
            err_switch <= 1'b0;
            err_orphan <= 1'b0;
            ovf        <= 1'b0;
        end else begin
            pr_n       <= ready_n_vec[rd_q];
            err_switch <= fr_switch;
            err_orphan <= fr_orphan;
            ovf        <= |q_sat;
        end
    end
endmodule

// File: rtl/pkt_ready_tracker_chk.sv
module pkt_ready_tracker_chk #(
    parameter int NUM_Q = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_mode,
    input logic             pr_n,
    input logic [NUM_Q-1:0] ready_n_vec,
    input logic             err_switch,
    input logic             err_orphan,
    input logic             ovf
);
    p_plain_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_mode |-> (pr_n && (&ready_n_vec)));

    p_plain_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_mode |-> !(err_switch || err_orphan || ovf));

    p_err_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_switch, err_orphan, ovf}));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> !(&ready_n_vec));

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pr_n && (&ready_n_vec) && !err_switch && !err_orphan && !ovf));
endmodule

bind pkt_ready_tracker pkt_ready_tracker_chk #(.NUM_Q(NUM_Q)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_mode    (pkt_mode),
    .pr_n        (pr_n),
    .ready_n_vec (ready_n_vec),
    .err_switch  (err_switch),
    .err_orphan  (err_orphan),
    .ovf         (ovf)
);

// File: tb/tb_pkt_ready_tracker.sv
module tb_pkt_ready_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_strap = 1'b1, in_w36 = 1'b1, out_w36 = 1'b1;
    logic        wr_en = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic [4:0]  wr_q = '0, rd_q = '0;
    logic        rd_en = 1'b0, rd_eop = 1'b0;
    logic        pr_n, err_switch, err_orphan, ovf;
    logic [31:0] ready_n_vec;
    int          checks = 0, failures = 0;

    always #4 clk = ~clk;

    pkt_ready_tracker dut (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .in_w36(in_w36), .out_w36(out_w36),
        .wr_en(wr_en), .wr_q(wr_q), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .rd_en(rd_en), .rd_q(rd_q), .rd_eop(rd_eop),
        .pr_n(pr_n), .ready_n_vec(ready_n_vec),
        .err_switch(err_switch), .err_orphan(err_orphan), .ovf(ovf)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // one clock: drive at negedge, result visible at following negedge
    task automatic step(input logic we, input int wq, input logic s, input logic e,
                        input logic re, input int rq, input logic reo);
        wr_en = we; wr_q = 5'(wq); wr_sop = s; wr_eop = e;
        rd_en = re; rd_q = 5'(rq); rd_eop = reo;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; rd_en = 1'b0; rd_eop = 1'b0;
    endtask

    task automatic idle(input int rq);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, rq, 1'b0);
    endtask

    task automatic do_reset(input logic s, input logic iw, input logic ow);
        @(negedge clk);
        rst_n = 1'b0; mode_strap = s; in_w36 = iw; out_w36 = ow;
        repeat (3) @(negedge clk);
        chk("R10 pr_n in reset", 32'(pr_n), 32'd1);
        chk("R10 vec in reset", ready_n_vec, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 errs after reset", 32'({err_switch, err_orphan, ovf}), 32'd0);
        chk("R10 vec after reset", ready_n_vec, 32'hFFFF_FFFF);
        mode_strap = ~s;   // strap moves after reset; mode must hold
    endtask

    task automatic t_multi_word;
        step(1'b1, 5, 1'b1, 1'b0, 1'b0, 5, 1'b0);
        chk("R2 open pkt not ready", 32'(ready_n_vec[5]), 32'd1);
        step(1'b1, 5, 1'b0, 1'b0, 1'b0, 5, 1'b0);
        step(1'b1, 5, 1'b0, 1'b1, 1'b0, 5, 1'b0);
        chk("R2 vec after close", 32'(ready_n_vec[5]), 32'd0);
        chk("R2 pr_n one edge late", 32'(pr_n), 32'd1);
        idle(5);
        chk("R2 pr_n low", 32'(pr_n), 32'd0);
        idle(6);
        chk("R2 pr_n other queue", 32'(pr_n), 32'd1);
    endtask

    task automatic t_single;
        step(1'b1, 9, 1'b1, 1'b1, 1'b0, 9, 1'b0);
        chk("R3 single word pkt", 32'(ready_n_vec[9]), 32'd0);
        chk("R3 no error", 32'({err_switch, err_orphan, ovf}), 32'd0);
    endtask

    task automatic t_read;
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 5, 1'b1);
        chk("R4 read eop clears q5", 32'(ready_n_vec[5]), 32'd1);
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 9, 1'b0);
        chk("R4 read non-eop keeps q9", 32'(ready_n_vec[9]), 32'd0);
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 9, 1'b1);
        chk("R4 read eop clears q9", 32'(ready_n_vec[9]), 32'd1);
    endtask

    task automatic t_simul;
        step(1'b1, 3, 1'b1, 1'b1, 1'b0, 3, 1'b0);
        step(1'b1, 3, 1'b1, 1'b1, 1'b1, 3, 1'b1);
        chk("R5 same-cycle hold", 32'(ready_n_vec[3]), 32'd0);
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 3, 1'b1);
        chk("R5 count was one", 32'(ready_n_vec[3]), 32'd1);
    endtask

    task automatic t_orphan;
        step(1'b1, 7, 1'b0, 1'b1, 1'b0, 7, 1'b0);
        chk("R6 orphan flagged", 32'(err_orphan), 32'd1);
        chk("R6 orphan not counted", 32'(ready_n_vec[7]), 32'd1);
        idle(7);
        chk("R6 orphan pulse ends", 32'(err_orphan), 32'd0);
    endtask

    task automatic t_switch;
        step(1'b1, 2, 1'b1, 1'b0, 1'b0, 2, 1'b0);
        step(1'b1, 4, 1'b0, 1'b1, 1'b0, 2, 1'b0);
        chk("R7 switch flagged", 32'(err_switch), 32'd1);
        chk("R7 no count q2/q4", 32'({ready_n_vec[2], ready_n_vec[4]}), 32'd3);
        step(1'b1, 2, 1'b0, 1'b1, 1'b0, 2, 1'b0);
        chk("R7 packet abandoned", 32'({err_switch, err_orphan}), 32'd1);
        chk("R7 q2 still empty", 32'(ready_n_vec[2]), 32'd1);
    endtask

    task automatic t_underflow;
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 10, 1'b1);
        chk("R9 empty read", 32'(ready_n_vec[10]), 32'd1);
        step(1'b1, 10, 1'b1, 1'b1, 1'b0, 10, 1'b0);
        chk("R9 no wrap then one pkt", 32'(ready_n_vec[10]), 32'd0);
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 10, 1'b1);
        chk("R9 back to zero", 32'(ready_n_vec[10]), 32'd1);
    endtask

    task automatic t_sat;
        int ovf_seen = 0;
        for (int i = 0; i < 15; i++) begin
            step(1'b1, 12, 1'b1, 1'b1, 1'b0, 12, 1'b0);
            if (ovf) ovf_seen++;
        end
        chk("R8 no ovf below max", 32'(ovf_seen), 32'd0);
        step(1'b1, 12, 1'b1, 1'b1, 1'b0, 12, 1'b0);
        chk("R8 ovf at max", 32'(ovf), 32'd1);
        for (int i = 0; i < 14; i++) step(1'b0, 0, 1'b0, 1'b0, 1'b1, 12, 1'b1);
        chk("R8 held at 15 not wrapped", 32'(ready_n_vec[12]), 32'd0);
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, 12, 1'b1);
        chk("R8 drained after 15", 32'(ready_n_vec[12]), 32'd1);
    endtask

    task automatic t_plain(input string tag);
        step(1'b1, 1, 1'b1, 1'b1, 1'b0, 1, 1'b0);
        idle(1);
        chk({"R1 plain vec ", tag}, ready_n_vec, 32'hFFFF_FFFF);
        chk({"R1 plain pr_n ", tag}, 32'(pr_n), 32'd1);
        step(1'b1, 1, 1'b0, 1'b1, 1'b0, 1, 1'b0);
        chk({"R1 plain no err ", tag}, 32'({err_switch, err_orphan, ovf}), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset(1'b1, 1'b1, 1'b1);
        t_multi_word();
        t_single();
        t_read();
        t_simul();
        t_orphan();
        t_switch();
        t_underflow();
        t_sat();
        do_reset(1'b1, 1'b0, 1'b1);
        t_plain("narrow in");
        do_reset(1'b1, 1'b1, 1'b0);
        t_plain("narrow out");
        do_reset(1'b0, 1'b1, 1'b1);
        t_plain("strap low");
        do_reset(1'b1, 1'b1, 1'b1);
        step(1'b1, 1, 1'b1, 1'b1, 1'b0, 1, 1'b0);
        chk("R1 packet mode back", 32'(ready_n_vec[1]), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule